// File: doc/BRIEF.md
# Pipelined Burst SRAM Core with Byte-Lane Writes

This block is the storage core of a synchronous burst SRAM. It holds an array of words split into two equal byte lanes (9 bits each in the default 18-bit build, 8 bits each in the 16-bit build). A start strobe loads a burst base address. An advance input then steps through a four-beat burst. The step order is either linear (wrapping within the beat field) or interleaved (the beat field is XORed with the step count).

Each clock edge does two things at the current burst address. It performs any write first. It then captures a read of that address into a data-out register, whose value is on `rdata` from that edge onward. There are two ways to request a write:

- An active-low global write writes both lanes.
- An active-low byte-write enable, together with per-lane active-low byte enables, writes only the selected lanes.

On an edge that samples the start strobe low, all write controls are ignored. The block has no tristate pin. Instead it produces `out_en`, which combines an asynchronous active-low output enable with a registered write-turnaround condition. That condition turns the drive off for the cycle after any sampled write request.

Top module: `burst_sram_core`

## Requirements
- R1: While `rst` is high at a clock edge, `rdata` becomes all zero and the write-turnaround state clears. After release, `out_en` is high when `oe_n` is low.
- R2: On an edge with `start_n` high and no write, `rdata` takes the word stored at the current burst address. The value appears after that edge and holds until the next edge.
- R3: On an edge with `start_n` high and `gw_n` low, both lanes at the current address are written from `wdata`, whatever `bwe_n` and `be_n` are.
- R4: On an edge with `start_n` high, `gw_n` high and `bwe_n` low, only the lanes whose `be_n` bit is low are written. `be_n[0]` selects lane 0 = `wdata[LANE_W-1:0]`. `be_n[1]` selects lane 1 = `wdata[DATA_W-1:LANE_W]`.
- R5: When `gw_n` and `bwe_n` are both high, no lane is written, whatever `be_n` is.
- R6: On an edge that samples `start_n` low, no lane is written. At that edge `start_n` low loads the address base and resets the beat count.
- R7: After an edge with `start_n` high where `gw_n` is low or any `be_n` bit is low, `out_en` is low until the next edge, regardless of `oe_n`. After an edge without such a request, the turnaround state clears.
- R8: `oe_n` high forces `out_en` low at once. `rdata` keeps updating while `oe_n` is high.
- R9: When `order_linear` is 1, each edge with `start_n` high and `adv_n` low advances the low two address bits to `(base + count) mod 4`. The beat wraps after four steps.
- R10: When `order_linear` is 0, the low two address bits are `base XOR count`.
- R11: A write edge updates `rdata` with the written lanes merged into the stored word. A read on the following edge returns the newly written data.
- R12: An edge with `start_n` high and `adv_n` high leaves the current burst address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Burst start strobe, active low; loads `addr` |
| adv_n | input | 1 | Burst advance, active low |
| order_linear | input | 1 | 1 = linear beat order, 0 = interleaved |
| addr | input | ADDR_W | Burst base address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| be_n | input | 2 | Per-lane byte enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| out_en | output | 1 | Output drive enable |

## Verification
A write and a read of the same word fall in the same cycle. Every write edge also captures the data-out register from the address being written. The bench provokes this with global and lane-selective writes to words preloaded with known patterns. It judges that `rdata` shows the merged word at once while `out_en` stays low, and that a plain read on the next edge returns the same word with `out_en` high again. A start edge carrying an active global write checks the opposite case: `rdata` must show the old word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES = 2;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } beat_order_e;

  // Decide whether one lane is written on this edge.
  function automatic logic lane_write(input logic start_n, input logic gw_n,
                                      input logic bwe_n, input logic be_n_lane);
    return start_n & (~gw_n | (~bwe_n & ~be_n_lane));
  endfunction
endpackage

// File: rtl/bsram_beat_addr.sv
module bsram_beat_addr
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  beat_order_e       order,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (order == ORD_LINEAR) beat = base_q[BEAT_W-1:0] + cnt_q;
    else                     beat = base_q[BEAT_W-1:0] ^ cnt_q;
    cur_addr = {base_q[ADDR_W-1:BEAT_W], beat};
  end
endmodule

// File: rtl/bsram_write_ctl.sv
module bsram_write_ctl
  import bsram_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic             start_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NLANE-1:0] be_n,
  output logic [NLANE-1:0] lane_we,
  output logic             bus_write
);
  for (genvar i = 0; i < NLANE; i++) begin : g_lane_dec
    assign lane_we[i] = lane_write(start_n, gw_n, bwe_n, be_n[i]);
  end

  // Any sampled write request turns the bus around, even with no lane selected.
  assign bus_write = start_n & (~gw_n | ~(&be_n));
endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Write-first output register.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (we) rdata <= wdata;
    else         rdata <= mem[addr];
  end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic              adv_n,
  input  logic              order_linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [1:0]        be_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              out_en
);
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;
  logic              bus_write;
  logic              drive_off_q;

  bsram_beat_addr #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (~start_n),
    .step     (start_n & ~adv_n),
    .order    (beat_order_e'(order_linear)),
    .load_addr(addr),
    .cur_addr (cur_addr)
  );

  bsram_write_ctl #(.NLANE(LANES)) u_wctl (
    .start_n  (start_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .be_n     (be_n),
    .lane_we  (lane_we),
    .bus_write(bus_write)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bsram_lane #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .we   (lane_we[i]),
      .addr (cur_addr),
      .wdata(wdata[i*LANE_W +: LANE_W]),
      .rdata(rdata[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) drive_off_q <= 1'b0;
    else     drive_off_q <= bus_write;
  end

  assign out_en = ~oe_n & ~drive_off_q;
endmodule

// File: rtl/burst_sram_core_chk.sv
module burst_sram_core_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_n,
  input logic              adv_n,
  input logic              gw_n,
  input logic              bwe_n,
  input logic [1:0]        be_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              out_en,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  lane_we
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (rdata == '0));

  assert_global_write_R3: assert property (@(posedge clk) disable iff (rst)
    (start_n && !gw_n) |-> (&lane_we));

  assert_byte_select_R4: assert property (@(posedge clk) disable iff (rst)
    (start_n && gw_n && !bwe_n) |-> (lane_we == ~be_n));

  assert_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (gw_n && bwe_n) |-> (lane_we == '0));

  assert_start_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    !start_n |-> (lane_we == '0));

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
    (start_n && (!gw_n || (be_n != 2'b11))) |=> !out_en);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !out_en);

  assert_write_first_R11: assert property (@(posedge clk) disable iff (rst)
    (start_n && !gw_n) |=> (rdata == $past(wdata)));

  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (start_n && adv_n) |=> $stable(cur_addr));
endmodule

bind burst_sram_core burst_sram_core_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_n (start_n),
  .adv_n   (adv_n),
  .gw_n    (gw_n),
  .bwe_n   (bwe_n),
  .be_n    (be_n),
  .oe_n    (oe_n),
  .wdata   (wdata),
  .rdata   (rdata),
  .out_en  (out_en),
  .cur_addr(cur_addr),
  .lane_we (lane_we)
);

// File: tb/burst_sram_core_bench.sv
module burst_sram_core_bench;
  localparam int DATA_W = 18;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_n = 1'b1, adv_n = 1'b1, order_linear = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [1:0]        be_n = 2'b11;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              out_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_sram_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_burst_sram_core (
    .clk(clk), .rst(rst), .start_n(start_n), .adv_n(adv_n),
    .order_linear(order_linear), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
    .be_n(be_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .out_en(out_en)
  );

  typedef struct packed {
    logic        st_n;
    logic        adv_n;
    logic        gw_n;
    logic        bwe_n;
    logic [1:0]  be_n;
    logic        oe_n;
    logic [7:0]  addr;
    logic [17:0] wd;
    logic        chk_rd;
    logic        x_oe;
    logic [17:0] x_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  // Linear order; words 0x14..0x17 preloaded with pat(a).
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,8'h14,18'h00000,1'b0,1'b1,18'h00000,4'd7},  // start clears R7
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22814,4'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22A15,4'd9},  // R9
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22C16,4'd9},
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22E17,4'd9},
    '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22814,4'd9},  // wrap
    '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22814,4'd12}, // R12 hold
    '{1'b1,1'b1,1'b1,1'b0,2'b01,1'b0,8'h00,18'h3FFFF,1'b1,1'b0,18'h3FE14,4'd4},  // R4 lane1, R7
    '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h3FE14,4'd11}, // R11
    '{1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b0,18'h00000,4'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,2'b11,1'b0,8'h00,18'h3FFFF,1'b1,1'b1,18'h00000,4'd4},  // R4 no lane
    '{1'b1,1'b1,1'b1,1'b1,2'b00,1'b0,8'h00,18'h3FFFF,1'b1,1'b0,18'h00000,4'd5},  // R5 and R7
    '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,8'h00,18'h00000,1'b1,1'b0,18'h00000,4'd8},  // R8
    '{1'b0,1'b1,1'b0,1'b1,2'b11,1'b0,8'h16,18'h12345,1'b1,1'b1,18'h00000,4'd6},  // R6
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22C16,4'd2},
    '{1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h22E17,4'd9},
    '{1'b1,1'b1,1'b1,1'b1,2'b11,1'b0,8'h00,18'h00000,1'b1,1'b1,18'h00000,4'd9}
  };

  function automatic logic [17:0] pat(input logic [7:0] a);
    return 18'h20000 | (18'(a) << 9) | 18'(a);
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check_rd(input int req, input logic [17:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL R%0d rdata actual %h expected %h", req, rdata, exp);
    end
  endtask

  task automatic check_oe(input int req, input logic exp);
    checks++;
    if (out_en !== exp) begin
      errors++;
      $display("FAIL R%0d out_en actual %b expected %b", req, out_en, exp);
    end
  endtask

  task automatic idle();
    start_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
    be_n = 2'b11; oe_n = 1'b0; wdata = '0;
  endtask

  initial begin
    idle();
    repeat (3) tick();
    rst = 1'b0;
    // R1: reset state
    check_rd(1, 18'h0);
    check_oe(1, 1'b1);

    for (int a = 16; a < 24; a++) begin
      start_n = 1'b0; addr = 8'(a);
      tick();
      start_n = 1'b1; gw_n = 1'b0; wdata = pat(8'(a));
      tick();
      gw_n = 1'b1;
    end

    for (int i = 0; i < NV; i++) begin
      start_n = VEC[i].st_n; adv_n = VEC[i].adv_n; gw_n = VEC[i].gw_n;
      bwe_n = VEC[i].bwe_n; be_n = VEC[i].be_n; oe_n = VEC[i].oe_n;
      addr = VEC[i].addr; wdata = VEC[i].wd;
      tick();
      check_oe(int'(VEC[i].req), VEC[i].x_oe);
      if (VEC[i].chk_rd) check_rd(int'(VEC[i].req), VEC[i].x_rd);
    end

    // R10: interleaved order from base 0x15 -> 15,14,17,16
    idle();
    order_linear = 1'b0;
    start_n = 1'b0; addr = 8'h15;
    tick();
    start_n = 1'b1; adv_n = 1'b0;
    tick();
    check_rd(10, 18'h22A15);
    oe_n = 1'b1;
    tick();
    check_rd(10, 18'h00000);
    check_oe(8, 1'b0);   // R8: data still moves while drive is off
    oe_n = 1'b0;
    tick();
    check_rd(10, 18'h22E17);
    tick();
    check_rd(10, 18'h22C16);
    check_oe(10, 1'b1);

    // R1: reset mid-run clears the data-out register
    idle();
    rst = 1'b1;
    tick();
    check_rd(1, 18'h0);
    rst = 1'b0;
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule